// File: doc/BRIEF.md
# Pipelined Late-Write Byte-Masked SRAM

This block is a synchronous single-port memory with a registered read path and late-write timing. A command is taken on each rising clock edge from two active-low strobes, together with an address and four active-low byte-lane enables. A read returns its word on the output bus one full cycle after the edge that took the command. A write takes its data from the data-in bus one cycle after its command, and that data is merged into the stored word under the byte-lane enables.

Because a write's data trails its command, the block holds the write address and lane enables for one cycle and commits the word when the data arrives. A read taken on that commit edge sees the array before the update, so a bypass path merges the incoming lanes into the read result when the addresses match. When both strobes are low, the cycle does nothing except set a sticky error flag. A synchronous active-high reset clears the control pipeline, the output register and the flag, and leaves the stored words untouched. The depth is set by a parameter. The default is 2048 words, and `ADDR_W = 15` gives the full 32,768-word by 32-bit organization.

Top module: `sram_latewrite`

## Requirements
- R1: The strobes are sampled on the rising edge. rd_n_i=0 with wr_n_i=1 is a read, rd_n_i=1 with wr_n_i=0 is a write, and both high is an idle cycle that changes nothing.
- R2: For a read taken on edge k, rdata_o carries the addressed word from just after edge k+1.
- R3: For a write taken on edge k, the data is taken from wdata_i on edge k+1, and the updated word is visible to any later read.
- R4: Byte-lane enable bsel_n_i[i] is active low and gates bits 8i+7..8i of the word. Lanes with the enable high keep their stored value. With all four high, the write leaves the word unchanged.
- R5: A read taken on the same edge that commits a pending write to the same address returns the old word with the enabled lanes replaced by the incoming data.
- R6: Reads and writes can be issued on every consecutive cycle in any mix, with one operation per clock.
- R7: Both strobes low is illegal. From the next edge on, illegal_o is 1 and stays 1 until reset. The cycle neither reads nor writes, and a write already waiting for its data still commits.
- R8: On cycles that carry no read result, rdata_o keeps its previous value.
- R9: rst_i is synchronous and active high. It drives rdata_o and illegal_o to 0 and drops a write still waiting for its data. The stored words are kept.
- R10: The whole address range, up to word 2^ADDR_W-1, can be written and read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Word address of the command |
| bsel_n_i | input | LANES | Byte-lane write enables, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| wdata_i | input | LANES*LANE_W | Write data, taken one cycle after the write command |
| rdata_o | output | LANES*LANE_W | Registered read data |
| illegal_o | output | 1 | Sticky flag for an illegal command |

## Verification
A read result is due one cycle after the edge that follows its command. A write's data is due on the bus in the cycle after its command, and the error flag is due right after the edge that samples the illegal command. The bench drives every input at the falling edge and samples at the next falling edge. Its reference model applies the pending commit before it looks up the array for a read on the same edge. It delays each expected read word by one step, so the output is compared in exactly the cycle in which it must change and is checked as held in every other cycle.

// File: rtl/sram_lw_pkg.sv
package sram_lw_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_READ = 2'd1,
    OP_WRITE = 2'd2,
    OP_BAD = 2'd3
  } op_e;

  function automatic op_e decode_op(input logic rd_n, input logic wr_n);
    case ({rd_n, wr_n})
      2'b01: decode_op = OP_READ;
      2'b10: decode_op = OP_WRITE;
      2'b11: decode_op = OP_IDLE;
      default: decode_op = OP_BAD;
    endcase
  endfunction

endpackage

// File: rtl/sram_cmd_dec.sv
module sram_cmd_dec
  import sram_lw_pkg::*;
(
  input  logic clk,
  input  logic rst_i,
  input  logic rd_n_i,
  input  logic wr_n_i,
  output logic rd_go_o,
  output logic wr_go_o,
  output logic illegal_o
);

  op_e op;

  always_comb begin
    op      = decode_op(rd_n_i, wr_n_i);
    rd_go_o = (op == OP_READ);
    wr_go_o = (op == OP_WRITE);
  end

  always_ff @(posedge clk) begin
    if (rst_i) illegal_o <= 1'b0;
    else if (op == OP_BAD) illegal_o <= 1'b1;
  end

  // R7: an illegal command raises the flag on the next edge
  a_r7_flag_set: assert property (@(posedge clk) disable iff (rst_i)
    (!rd_n_i && !wr_n_i) |=> illegal_o);

  // R7: the flag is sticky until reset
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst_i)
    illegal_o |=> illegal_o);

  // R9: reset clears the flag
  a_r9_flag_cleared: assert property (@(posedge clk) rst_i |=> !illegal_o);

endmodule

// File: rtl/sram_wr_pend.sv
module sram_wr_pend #(
  parameter int ADDR_W = 11,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_i,
  input  logic              wr_go_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  bsel_n_i,
  output logic              pend_v_o,
  output logic [ADDR_W-1:0] pend_addr_o,
  output logic [LANES-1:0]  pend_lane_o
);

  always_ff @(posedge clk) begin
    if (rst_i) begin
      pend_v_o <= 1'b0;
    end else begin
      pend_v_o <= wr_go_i;
    end
    if (wr_go_i) begin
      pend_addr_o <= addr_i;
      pend_lane_o <= ~bsel_n_i;
    end
  end

  // R3: a write command leaves a pending commit for the data cycle
  a_r3_pending_after_write: assert property (@(posedge clk) disable iff (rst_i)
    wr_go_i |=> pend_v_o);

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int ADDR_W = 11,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES-1:0]        wlane_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    re_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (we_i && wlane_i[g])
        store[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
      if (re_i)
        rdata_o[g*LANE_W +: LANE_W] <= store[raddr_i];
    end
  end

endmodule

// File: rtl/sram_latewrite.sv
module sram_latewrite
  import sram_lw_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        bsel_n_i,
  input  logic                    rd_n_i,
  input  logic                    wr_n_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    illegal_o
);

  localparam int DATA_W = LANES * LANE_W;

  logic              rd_go, wr_go;
  logic              pend_v;
  logic [ADDR_W-1:0] pend_addr;
  logic [LANES-1:0]  pend_lane;
  logic              commit;
  logic [DATA_W-1:0] ram_q;

  // stage A: read issued, bypass captured
  logic              rd_a;
  logic              hit_a;
  logic [LANES-1:0]  hit_lane_a;
  logic [DATA_W-1:0] hit_data_a;
  logic [DATA_W-1:0] merged;

  sram_cmd_dec u_dec (
    .clk      (clk),
    .rst_i    (rst_i),
    .rd_n_i   (rd_n_i),
    .wr_n_i   (wr_n_i),
    .rd_go_o  (rd_go),
    .wr_go_o  (wr_go),
    .illegal_o(illegal_o)
  );

  sram_wr_pend #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pend (
    .clk        (clk),
    .rst_i      (rst_i),
    .wr_go_i    (wr_go),
    .addr_i     (addr_i),
    .bsel_n_i   (bsel_n_i),
    .pend_v_o   (pend_v),
    .pend_addr_o(pend_addr),
    .pend_lane_o(pend_lane)
  );

  assign commit = pend_v && !rst_i;

  sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_ram (
    .clk    (clk),
    .we_i   (commit),
    .waddr_i(pend_addr),
    .wlane_i(pend_lane),
    .wdata_i(wdata_i),
    .re_i   (rd_go),
    .raddr_i(addr_i),
    .rdata_o(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst_i) begin
      rd_a  <= 1'b0;
      hit_a <= 1'b0;
    end else begin
      rd_a  <= rd_go;
      hit_a <= rd_go && pend_v && (pend_addr == addr_i);
    end
    hit_lane_a <= pend_lane;
    hit_data_a <= wdata_i;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[g*LANE_W +: LANE_W] = (hit_a && hit_lane_a[g]) ?
      hit_data_a[g*LANE_W +: LANE_W] : ram_q[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst_i) rdata_o <= '0;
    else if (rd_a) rdata_o <= merged;
  end

  // R8: output held on cycles without a read result
  a_r8_hold: assert property (@(posedge clk) disable iff (rst_i)
    !rd_a |=> $stable(rdata_o));

  // R1: a read command leaves no pending write behind
  a_r1_read_no_pending: assert property (@(posedge clk) disable iff (rst_i)
    (!rd_n_i && wr_n_i) |=> !pend_v);

  // R7: an illegal command leaves no pending write behind
  a_r7_no_write: assert property (@(posedge clk) disable iff (rst_i)
    (!rd_n_i && !wr_n_i) |=> !pend_v);

  // R2: a read command yields a result in stage A
  a_r2_read_staged: assert property (@(posedge clk) disable iff (rst_i)
    (!rd_n_i && wr_n_i) |=> rd_a);

endmodule

// File: tb/sim_sram_latewrite.sv
`timescale 1ns/1ps
module sim_sram_latewrite;

  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_i = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [3:0]    bsel_n_i = 4'hF;
  logic          rd_n_i = 1'b1;
  logic          wr_n_i = 1'b1;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic          illegal_o;

  always #2.5 clk = ~clk;

  sram_latewrite #(.ADDR_W(AW), .LANES(4), .LANE_W(8)) u0 (
    .clk(clk), .rst_i(rst_i), .addr_i(addr_i), .bsel_n_i(bsel_n_i),
    .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .illegal_o(illegal_o)
  );

  int vectors = 0;
  int miscompares = 0;

  logic [31:0]   exp_mem [DEPTH];
  logic          pw_v = 1'b0;
  logic [AW-1:0] pw_a;
  logic [3:0]    pw_be;
  logic          prev_rd = 1'b0;
  logic [31:0]   prev_val;
  string         prev_tag;
  logic [31:0]   exp_dout = '0;
  logic          exp_err = 1'b0;

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] ben);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++)
      if (!ben[i]) r[i*8 +: 8] = nw[i*8 +: 8];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // one clock step: drive at the falling edge, model at the rising edge, check at the next falling edge
  task automatic cyc(input logic rdn, input logic wrn, input logic [AW-1:0] a,
                     input logic [3:0] ben, input logic [31:0] d, input string tag);
    logic had_rd;
    string rtag;
    logic nrd;
    logic [31:0] nval;
    rd_n_i = rdn; wr_n_i = wrn; addr_i = a; bsel_n_i = ben; wdata_i = d;
    @(posedge clk);
    if (pw_v) exp_mem[pw_a] = merge(exp_mem[pw_a], d, pw_be);
    nrd = !rdn && wrn;
    nval = exp_mem[a];
    if (!rdn && !wrn) exp_err = 1'b1;
    had_rd = prev_rd;
    rtag = prev_tag;
    if (prev_rd) exp_dout = prev_val;
    pw_v = rdn && !wrn; pw_a = a; pw_be = ben;
    prev_rd = nrd; prev_val = nval; prev_tag = tag;
    @(negedge clk);
    check(had_rd ? rtag : "R8", rdata_o, exp_dout);
    check("R7", {31'd0, illegal_o}, {31'd0, exp_err});
  endtask

  task automatic nop(input string tag);
    cyc(1'b1, 1'b1, '0, 4'hF, $urandom, tag);
  endtask

  task automatic do_reset(input int n);
    rst_i = 1'b1; rd_n_i = 1'b1; wr_n_i = 1'b1;
    @(posedge clk);
    pw_v = 1'b0; prev_rd = 1'b0; exp_dout = '0; exp_err = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk);
    rst_i = 1'b0;
    check("R9", rdata_o, 32'd0);
    check("R9", {31'd0, illegal_o}, 1'b0 ? 32'd1 : 32'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset(3);

    // fill the whole array; R10 covers the top word
    for (int a = 0; a < DEPTH; a++)
      cyc(1'b1, 1'b0, a[AW-1:0], 4'h0, $urandom, "R10");
    nop("R3");
    cyc(1'b0, 1'b1, AW'(DEPTH-1), 4'hF, 32'd0, "R10");
    cyc(1'b0, 1'b1, '0, 4'hF, 32'd0, "R10");
    nop("R8"); nop("R8");

    // R2: single read, then idle
    cyc(1'b0, 1'b1, AW'(5), 4'hF, 32'd0, "R2");
    nop("R8"); nop("R8");

    // R3 / R4: late write with partial lanes, then read back
    cyc(1'b1, 1'b0, AW'(7), 4'b1010, 32'h0, "R4");
    cyc(1'b1, 1'b1, '0, 4'hF, 32'hA1B2C3D4, "R3");
    cyc(1'b0, 1'b1, AW'(7), 4'hF, 32'd0, "R4");
    nop("R8");
    cyc(1'b1, 1'b0, AW'(7), 4'hF, 32'h0, "R4");
    cyc(1'b0, 1'b1, AW'(7), 4'hF, 32'hFFFFFFFF, "R4");
    nop("R8");

    // R5: read on the commit edge, full and partial lanes
    cyc(1'b1, 1'b0, AW'(9), 4'h0, 32'h0, "R5");
    cyc(1'b0, 1'b1, AW'(9), 4'hF, 32'h12345678, "R5");
    cyc(1'b1, 1'b0, AW'(9), 4'b0110, 32'h0, "R5");
    cyc(1'b0, 1'b1, AW'(9), 4'hF, 32'hCAFEF00D, "R5");
    cyc(1'b1, 1'b0, AW'(9), 4'h0, 32'h0, "R5");
    cyc(1'b0, 1'b1, AW'(10), 4'hF, 32'h55AA55AA, "R5");
    nop("R8");

    // R1: idle cycles with busy address and data lines
    cyc(1'b1, 1'b1, AW'(9), 4'h0, 32'hDEADBEEF, "R1");
    cyc(1'b0, 1'b1, AW'(9), 4'hF, 32'd0, "R1");
    nop("R8");

    // R7: illegal command right after a write
    cyc(1'b1, 1'b0, AW'(12), 4'h0, 32'h0, "R7");
    cyc(1'b0, 1'b0, AW'(13), 4'h0, 32'h600DD00D, "R7");
    cyc(1'b0, 1'b1, AW'(12), 4'hF, 32'h0, "R7");
    cyc(1'b0, 1'b1, AW'(13), 4'hF, 32'h0, "R7");
    nop("R8");

    // R9: reset clears the flag, drops the pending write, keeps the array
    cyc(1'b1, 1'b0, AW'(3), 4'h0, 32'h0, "R9");
    rst_i = 1'b1; rd_n_i = 1'b1; wr_n_i = 1'b1; wdata_i = 32'hBAD0BAD0;
    do_reset(2);
    cyc(1'b0, 1'b1, AW'(3), 4'hF, 32'h0, "R9");
    cyc(1'b0, 1'b1, AW'(12), 4'hF, 32'h0, "R9");
    nop("R8");

    // R6: random back-to-back mix in a small window
    for (int i = 0; i < 4000; i++) begin
      int k = $urandom_range(0, 99);
      logic rdn, wrn;
      if (k < 45)      begin rdn = 1'b0; wrn = 1'b1; end
      else if (k < 90) begin rdn = 1'b1; wrn = 1'b0; end
      else if (k < 99) begin rdn = 1'b1; wrn = 1'b1; end
      else             begin rdn = 1'b0; wrn = 1'b0; end
      cyc(rdn, wrn, AW'($urandom_range(0, 15)), 4'($urandom), $urandom, "R6");
      if ((i % 1000) == 999) do_reset(1);
    end
    nop("R8"); nop("R8");
    finish_run();
  end

endmodule